// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It gives a bus master read and write access to a small bank of byte-wide configuration registers. SCL and SDA are first brought into a system clock that runs much faster than SCL. The block then finds start and stop conditions on the synchronised lines and shifts bytes in and out. Its only drive on the bus is an enable that pulls SDA low. A write transaction always begins by loading a write-only subaddress pointer. That pointer then steps by one after every data byte, in write bursts and in read bursts alike. To read, the master first writes the subaddress, then issues a repeated start with the read bit set.

Four neighbouring registers form a 32-bit frequency word. The lowest of the four is the least significant byte. The word on the output changes in one clock cycle, and only after one write burst has covered all four bytes in order, starting at the lowest. Every other register can be written or read on its own.

The block protects its state against bad traffic. A subaddress that does not exist gets no acknowledge. A write past the end of the bank gets no acknowledge and stores nothing. A read past the end keeps returning the top register. A start or stop condition in the middle of a byte abandons that byte.

Top module: `twi_reg_slave`

## Requirements
- R1: While reset is held and after it is released, sda_oe is low, every register in cfg_regs is zero, and freq_word is zero.
- R2: The first byte after a start holds the 7-bit device address, MSB first, followed by a direction bit (0 means write, 1 means read). The slave acknowledges it by pulling SDA low on the ninth clock only when the address equals DEV_ADDR. On a mismatch it stays released and ignores every byte up to the next start.
- R3: In a write transaction, the byte after the address is loaded into the subaddress pointer. Each following data byte is stored in the register at the pointer, and the pointer then steps by one. Register k appears on cfg_regs bits [8k+7:8k].
- R4: A subaddress of NUM_REGS or more gets no acknowledge, and the slave returns to idle. Any data byte that follows is neither acknowledged nor stored.
- R5: After a repeated start with the read bit set, the slave returns the register at the pointer, MSB first, and steps the pointer after each byte. The pointer keeps the value set by the earlier write phase.
- R6: In a write burst, a data byte that arrives after register NUM_REGS-1 has been written is not stored. It gets no acknowledge, and the slave returns to idle.
- R7: In a read burst that runs past register NUM_REGS-1, the slave keeps returning that top register. When the master leaves SDA high on the ninth clock, the slave releases SDA and returns to idle.
- R8: freq_word equals {reg[B+3], reg[B+2], reg[B+1], reg[B]}, where B is FREQ_BASE. It is updated only when a single write burst whose subaddress was B stores its fourth byte.
- R9: Writes that touch the frequency registers leave freq_word unchanged if they are single, partial, or begin above B.
- R10: A start condition at any bit position moves the slave to the address phase, and a stop condition moves it to idle. In both cases the partly received byte is discarded.
- R11: A stop followed by a start within one SCL high period ends the first transaction and opens a new one that works normally.
- R12: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| cfg_regs | output | NUM_REGS*8 | Flattened register bank, register k in bits [8k+7:8k] |
| freq_word | output | 32 | Committed frequency word |

## Verification
The bench builds the block with six registers, the frequency group at subaddresses 2 to 5, and device address 0x5A. With only six registers, a three-byte write burst from subaddress 4, or a four-byte read from subaddress 3, is enough to run off the end of the bank. Because the frequency group ends at the top register, a read past the end repeats the last frequency byte. The group also sits above register 0, so bursts that begin below it, at its base, or inside it can each be compared.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_MACK
  } twi_state_e;

  // Frequency word assembly: the byte at the group base is least significant.
  function automatic logic [31:0] freq_pack(input logic [7:0] b0, input logic [7:0] b1,
                                            input logic [7:0] b2, input logic [7:0] b3);
    return {b3, b2, b1, b0};
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, sda_m, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_reg_bank.sv
`timescale 1ns/1ps
module twi_reg_bank #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] rd_clamped;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (wr_en && wr_idx == IDX_W'(gi))     q <= wr_data;
    end
    assign regs_flat[gi*8 +: 8] = q;
  end

  // Reads beyond the end return the top register.
  assign rd_clamped = (rd_idx > TOP_IDX) ? TOP_IDX : rd_idx;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_clamped == IDX_W'(i)) rd_data = regs_flat[i*8 +: 8];
  end

  AST_WR_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx <= TOP_IDX)) else $error("write beyond bank");  // R6
endmodule

// File: rtl/twi_freq_shadow.sv
`timescale 1ns/1ps
module twi_freq_shadow import twi_pkg::*; #(
  parameter int IDX_W = 5,
  parameter int BASE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_ev,
  input  logic [IDX_W-1:0] begin_idx,
  input  logic             abort,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [31:0]      freq_word,
  output logic             commit_ev
);
  localparam logic [IDX_W-1:0] BASE_I = IDX_W'(BASE);
  localparam logic [IDX_W-1:0] TOP_I  = IDX_W'(BASE + 3);

  logic       armed;
  logic [1:0] step;
  logic [7:0] sh [3];
  logic       in_order;

  assign in_order  = armed && (wr_idx == BASE_I + IDX_W'(step));
  assign commit_ev = wr_en && in_order && (step == 2'd3) && !abort && !begin_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; step <= '0; freq_word <= '0;
      sh[0] <= '0; sh[1] <= '0; sh[2] <= '0;
    end else if (abort) begin
      armed <= 1'b0;
    end else if (begin_ev) begin
      armed <= (begin_idx == BASE_I);
      step  <= '0;
    end else if (wr_en) begin
      if (in_order && step == 2'd3) begin
        freq_word <= freq_pack(sh[0], sh[1], sh[2], wr_data);
        armed     <= 1'b0;
      end else if (in_order) begin
        sh[step] <= wr_data;
        step     <= step + 2'd1;
      end else begin
        armed <= 1'b0;
      end
    end
  end

  AST_COMMIT_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_word) |-> $past(wr_en && wr_idx == TOP_I)) else $error("early commit");  // R8
  AST_HOLD_OFF_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != TOP_I) |=> $stable(freq_word)) else $error("word moved");  // R9
endmodule

// File: rtl/twi_reg_slave.sv
`timescale 1ns/1ps
module twi_reg_slave import twi_pkg::*; #(
  parameter logic [6:0] DEV_ADDR  = 7'h2D,
  parameter int         NUM_REGS  = 16,
  parameter int         FREQ_BASE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs,
  output logic [31:0]           freq_word
);
  localparam int               IDX_W   = $clog2(NUM_REGS + 1);
  localparam logic [IDX_W-1:0] PTR_END = IDX_W'(NUM_REGS);

  function automatic logic sub_in_range(input logic [7:0] v);
    return {24'd0, v} < 32'(NUM_REGS);
  endfunction

  function automatic logic [IDX_W-1:0] ptr_step(input logic [IDX_W-1:0] p);
    return (p == PTR_END) ? p : p + IDX_W'(1);
  endfunction

  twi_state_e       state;
  logic [3:0]       cnt;
  logic [7:0]       rx, tx, rd_byte;
  logic [IDX_W-1:0] ptr, ptr_next;
  logic             rw, oe_q, macked;

  // Named events
  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic byte_full, byte_end, addr_hit, addr_reject, sub_accept, sub_reject;
  logic wr_en, wr_overrun, ld_ev, read_end, commit_ev;

  twi_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(ev_start), .stop_ev(ev_stop)
  );

  assign byte_full   = (cnt == 4'd8);
  assign byte_end    = scl_fall && byte_full;
  assign addr_hit    = (rx[7:1] == DEV_ADDR);
  assign addr_reject = byte_end && state == ST_ADDR && !addr_hit;
  assign sub_accept  = byte_end && state == ST_SUB && sub_in_range(rx);
  assign sub_reject  = byte_end && state == ST_SUB && !sub_in_range(rx);
  assign wr_en       = byte_end && state == ST_WDATA && ptr != PTR_END;
  assign wr_overrun  = byte_end && state == ST_WDATA && ptr == PTR_END;
  assign ld_ev       = scl_fall && ((state == ST_ADDR_ACK && rw) || (state == ST_MACK && macked));
  assign read_end    = scl_fall && state == ST_MACK && !macked;
  assign ptr_next    = ptr_step(ptr);

  twi_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(rx),
    .rd_idx(ptr), .rd_data(rd_byte), .regs_flat(cfg_regs)
  );

  twi_freq_shadow #(.IDX_W(IDX_W), .BASE(FREQ_BASE)) u_freq (
    .clk(clk), .rst_n(rst_n), .begin_ev(sub_accept), .begin_idx(rx[IDX_W-1:0]),
    .abort(ev_start | ev_stop), .wr_en(wr_en), .wr_idx(ptr), .wr_data(rx),
    .freq_word(freq_word), .commit_ev(commit_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; rx <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; oe_q <= 1'b0; macked <= 1'b0;
    end else if (ev_stop) begin
      state <= ST_IDLE; oe_q <= 1'b0; cnt <= '0;
    end else if (ev_start) begin
      state <= ST_ADDR; oe_q <= 1'b0; cnt <= '0;
    end else if (ld_ev) begin
      tx    <= rd_byte;
      oe_q  <= ~rd_byte[7];
      ptr   <= ptr_next;
      cnt   <= '0;
      state <= ST_TX;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise && !byte_full) begin
            rx  <= {rx[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit) begin rw <= rx[0]; oe_q <= 1'b1; state <= ST_ADDR_ACK; end
              else state <= ST_IDLE;
            end else if (state == ST_SUB) begin
              if (sub_accept) begin ptr <= rx[IDX_W-1:0]; oe_q <= 1'b1; state <= ST_SUB_ACK; end
              else state <= ST_IDLE;
            end else begin
              if (wr_en) begin ptr <= ptr_next; oe_q <= 1'b1; state <= ST_WDATA_ACK; end
              else state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin oe_q <= 1'b0; state <= ST_SUB; end
        ST_SUB_ACK, ST_WDATA_ACK: if (scl_fall) begin oe_q <= 1'b0; state <= ST_WDATA; end
        ST_TX: if (scl_fall) begin
          if (cnt == 4'd7) begin
            oe_q <= 1'b0; cnt <= '0; state <= ST_MACK;
          end else begin
            tx   <= {tx[6:0], 1'b0};
            oe_q <= ~tx[6];
            cnt  <= cnt + 4'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) macked <= ~sda_s;
          if (read_end) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s) else $error("SDA moved with SCL high");  // R12
  AST_ADDR_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_reject |=> (state == ST_IDLE && !oe_q)) else $error("address miss acked");  // R2
  AST_BAD_SUB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reject |=> (state == ST_IDLE && !oe_q)) else $error("bad subaddress acked");  // R4
  AST_OVERRUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overrun |=> (state == ST_IDLE && !oe_q && $stable(cfg_regs))) else $error("overrun stored");  // R6
  AST_READ_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    read_end |=> (state == ST_IDLE && !oe_q)) else $error("read not ended");  // R7
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == ST_ADDR && cnt == 4'd0 && !oe_q)) else $error("start ignored");  // R10
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (state == ST_IDLE && !oe_q)) else $error("stop ignored");  // R10
  AST_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> (state == ST_WDATA && wr_en)) else $error("commit outside write");  // R8
endmodule

// File: tb/twi_reg_slave_bench.sv
`timescale 1ns/1ps
module twi_reg_slave_bench;
  localparam logic [6:0] DEV  = 7'h5A;
  localparam int         NREG = 6;
  localparam int         FB   = 2;
  localparam int         H    = 20;

  // Vector table: {subaddress, data} single-register writes, each read back.
  localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h015A, 16'h02C3, 16'h037E, 16'h0401, 16'h05FF};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl_m, sda_m;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_regs;
  logic [31:0] freq_word;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  twi_reg_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .FREQ_BASE(FB)) u_twi_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs), .freq_word(freq_word)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];
  logic [31:0] exp_freq;

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask
  task automatic bus_stop_start();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(H);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2); b = sda_line; tick(H/2); scl_m = 1'b0; tick(H);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(output logic [7:0] d, input logic more);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~more);
  endtask

  // acks: [0] device, [1] subaddress, [2+i] data byte i
  task automatic wr_burst(input logic [7:0] sub, input int n, input logic [31:0] data,
                          output logic [5:0] acks);
    logic a;
    acks = '0;
    bus_start();
    send_byte({DEV, 1'b0}, a); acks[0] = a;
    send_byte(sub, a);         acks[1] = a;
    for (int i = 0; i < n; i++) begin send_byte(data[i*8 +: 8], a); acks[2+i] = a; end
    bus_stop();
  endtask

  // acks: [0] device write, [1] subaddress, [2] device read
  task automatic rd_burst(input logic [7:0] sub, input int n, output logic [31:0] got,
                          output logic [2:0] acks);
    logic a;
    logic [7:0] d;
    got = '0;
    bus_start();
    send_byte({DEV, 1'b0}, a); acks[0] = a;
    send_byte(sub, a);         acks[1] = a;
    bus_start();
    send_byte({DEV, 1'b1}, a); acks[2] = a;
    for (int i = 0; i < n; i++) begin recv_byte(d, i < n - 1); got[i*8 +: 8] = d; end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] wa;
    logic [2:0] ra;
    logic [31:0] got;
    logic a;

    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    exp_freq = 32'h0;
    tick(6);
    chk("R1 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    chk("R1 regs in reset", {31'd0, cfg_regs == '0}, 32'd1);
    rst_n = 1'b1;
    tick(6);
    chk("R1 freq after reset", freq_word, 32'h0);

    // Table walk: single write, lane check, single read back
    for (int v = 0; v < 6; v++) begin
      int idx;
      idx = int'(VEC[v][15:8]);
      wr_burst(VEC[v][15:8], 1, {24'd0, VEC[v][7:0]}, wa);
      model[idx] = VEC[v][7:0];
      chk("R2 device ack", {31'd0, wa[0]}, 32'd1);
      chk("R3 sub and data ack", {30'd0, wa[2:1]}, 32'd3);
      chk("R3 register lane", {24'd0, cfg_regs[idx*8 +: 8]}, {24'd0, VEC[v][7:0]});
      rd_burst(VEC[v][15:8], 1, got, ra);
      chk("R5 read acks", {29'd0, ra}, 32'd7);
      chk("R5 read back", got, {24'd0, VEC[v][7:0]});
      chk("R9 single write no commit", freq_word, exp_freq);
    end

    // R2: wrong device address, following bytes ignored
    bus_start();
    send_byte({7'h5B, 1'b0}, a); chk("R2 foreign address nack", {31'd0, a}, 32'd0);
    send_byte(8'h00, a);         chk("R2 ignored until start", {31'd0, a}, 32'd0);
    send_byte(8'h11, a);         chk("R2 ignored data", {31'd0, a}, 32'd0);
    bus_stop();
    chk("R2 bank untouched", {31'd0, cfg_regs == model_flat()}, 32'd1);

    // R4: subaddress out of range
    wr_burst(8'd6, 1, 32'h99, wa);
    chk("R4 device ack", {31'd0, wa[0]}, 32'd1);
    chk("R4 bad sub nack", {31'd0, wa[1]}, 32'd0);
    chk("R4 data after bad sub nack", {31'd0, wa[2]}, 32'd0);
    chk("R4 bank untouched", {31'd0, cfg_regs == model_flat()}, 32'd1);

    // R6: write past the end of the bank
    wr_burst(8'd4, 3, 32'h00332211, wa);
    model[4] = 8'h11; model[5] = 8'h22;
    chk("R6 in-range acks", {28'd0, wa[3:0]}, 32'hF);
    chk("R6 overrun nack", {31'd0, wa[4]}, 32'd0);
    chk("R6 bank contents", {31'd0, cfg_regs == model_flat()}, 32'd1);
    chk("R9 burst from above base", freq_word, exp_freq);

    // R5/R7: read burst past the end repeats top register
    rd_burst(8'd3, 4, got, ra);
    chk("R7 read past end", got, {model[5], model[5], model[4], model[3]});
    chk("R7 released after nack", {31'd0, sda_oe}, 32'd0);

    // R8: in-order burst from base commits
    wr_burst(8'(FB), 4, 32'h87654321, wa);
    model[2] = 8'h21; model[3] = 8'h43; model[4] = 8'h65; model[5] = 8'h87;
    exp_freq = 32'h87654321;
    chk("R8 burst acks", {26'd0, wa}, 32'h3F);
    chk("R8 commit", freq_word, exp_freq);

    // R9: partial burst from base, and burst starting inside group
    wr_burst(8'(FB), 2, 32'h0000BBAA, wa);
    model[2] = 8'hAA; model[3] = 8'hBB;
    chk("R9 partial burst", freq_word, exp_freq);
    wr_burst(8'd3, 3, 32'h00CCDDEE, wa);
    model[3] = 8'hEE; model[4] = 8'hDD; model[5] = 8'hCC;
    chk("R9 burst from inside group", freq_word, exp_freq);
    chk("R9 bank still written", {31'd0, cfg_regs == model_flat()}, 32'd1);

    // R8: second full commit with other data
    wr_burst(8'(FB), 4, 32'h0D0C0B0A, wa);
    model[2] = 8'h0A; model[3] = 8'h0B; model[4] = 8'h0C; model[5] = 8'h0D;
    exp_freq = 32'h0D0C0B0A;
    chk("R8 second commit", freq_word, exp_freq);

    // R10: start in the middle of a data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd0, a);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R10 address after mid-byte start", {31'd0, a}, 32'd1);
    send_byte(8'd1, a);
    send_byte(8'h3C, a);       chk("R10 data ack after restart", {31'd0, a}, 32'd1);
    bus_stop();
    model[1] = 8'h3C;
    chk("R10 partial byte discarded", {31'd0, cfg_regs == model_flat()}, 32'd1);

    // R10: stop in the middle of a data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd0, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk("R10 stop discards byte", {24'd0, cfg_regs[7:0]}, {24'd0, model[0]});
    chk("R10 idle after stop", {31'd0, sda_oe}, 32'd0);

    // R11: stop and start within one SCL high period
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd0, a);
    send_byte(8'h77, a);
    bus_stop_start();
    send_byte({DEV, 1'b0}, a); chk("R11 address after stop-start", {31'd0, a}, 32'd1);
    send_byte(8'd1, a);
    send_byte(8'h66, a);       chk("R11 data after stop-start", {31'd0, a}, 32'd1);
    bus_stop();
    model[0] = 8'h77; model[1] = 8'h66;
    rd_burst(8'd0, 2, got, ra);
    chk("R11 both transactions stored", got, 32'h00006677);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule